// File: doc/BRIEF.md
# Serial Word Framer with Header-Triggered Realignment

This block sits behind the descrambler of a serial video receiver and runs on the bit clock. It shifts the incoming bit stream into a window and looks for the timing header that opens every active-line start and end marker. The header is one all-ones word followed by two all-zeros words, with each word sent least significant bit first. A divide-by-word-width counter groups the stream into parallel words. While the header is absent, the counter keeps its phase. When a header is found, the counter is forced back to its start, so the next bit becomes bit 0 of a new word.

Each header flips the level of a status output instead of pulsing it. A control state machine then waits for the next complete word, the marker word. Its H flag bit tells an end-of-line marker from a start-of-line marker, and the result is held on an output. Downstream logic takes one parallel word per strobe. The strobe is one bit-clock cycle wide and comes once every word-width cycles.

Top module: `trs_framer`

## Requirements
- R1: While `rst_n` is low, `word_stb`, `h_level`, `hdr_eav` and `par_word` are all 0.
- R2: Without a header, `word_stb` is high for exactly one cycle in every 10. It is never high on two cycles in a row. After reset the first strobe follows the 10th bit clocked in.
- R3: Whenever `word_stb` is high, `par_word` holds the last 10 bits received. The earliest of them is in bit 0. The word stays unchanged until the next strobe.
- R4: A header is detected when the last 30 received bits are ten ones followed by twenty zeros, in arrival order. Preambles of both marker kinds are detected the same way.
- R5: `h_level` inverts once per detected header. The change shows one clock after the edge that captured the last header bit.
- R6: After a header, the first bit received becomes bit 0 of the next word. That word is strobed after its 10th bit, whatever the earlier phase.
- R7: No strobe is produced in the cycle where the word phase is realigned. No part-filled word is ever emitted.
- R8: On the strobe of the first word after a header, `hdr_eav` takes bit 6 of that word (1 = end marker, 0 = start marker). It holds that value until the next such word.
- R9: A 30-bit window that differs from the header pattern in any bit leaves `h_level` unchanged.
- R10: A header at the current word phase keeps the 10-cycle strobe spacing unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Descrambled serial data, one bit per clock |
| par_word | output | 10 | Last completed parallel word, earliest bit in bit 0 |
| word_stb | output | 1 | One-cycle strobe marking a new word on `par_word` |
| h_level | output | 1 | Level that inverts on every detected header |
| hdr_eav | output | 1 | Class of the latest marker word: 1 end, 0 start |

## Verification
The assertions assume the stream delivers at most one header per 30 bits. This always holds, because the pattern cannot overlap itself. They also assume bits arrive on every clock with no gaps. The stimulus sends whole words, or a chosen number of zero pad bits, on every clock edge. Each data word placed before a deliberate near-miss has a 0 in its top bit. This stops the preceding word from completing a real header at a shifted offset.

// File: rtl/trs_pkg.sv
// Shared definitions for the serial word framer.
// Assumes one serial bit per clock and a header of one all-ones word plus zero words.
package trs_pkg;
    localparam int WORD_W_DEF    = 10;
    localparam int HDR_WORDS_DEF = 3;
    localparam int H_BIT_DEF     = 6;

    // Control state: free tracking, or waiting for the marker word
    typedef enum logic {
        ST_TRACK    = 1'b0,
        ST_CLASSIFY = 1'b1
    } frame_state_e;
endpackage

// File: rtl/trs_seq_detect.sv
// Header search window.
// Shifts the serial stream in, earliest bit toward index 0, and flags a header
// when the registered window equals the preamble pattern.
// Also offers the word that the next clock edge would complete.
// Assumes one new bit on every clock.
module trs_seq_detect #(
    parameter int WORD_W    = 10,
    parameter int HDR_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_next,
    output logic              hdr_hit
);
    localparam int PAT_W = WORD_W * HDR_WORDS;

    logic [PAT_W-1:0] win_q;
    logic [PAT_W-1:0] win_d;
    logic [PAT_W-1:0] pattern;

    // Preamble pattern: first word all ones, the rest all zeros
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_pat
        if (g == 0) begin : g_ones
            assign pattern[g*WORD_W +: WORD_W] = '1;
        end else begin : g_zeros
            assign pattern[g*WORD_W +: WORD_W] = '0;
        end
    end

    // Next window contents: the new bit enters at the top
    always_comb win_d = {bit_in, win_q[PAT_W-1:1]};

    // Window register
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    // Header match on the registered window
    always_comb hdr_hit = (win_q == pattern);

    // Word completed if this edge closes a word
    always_comb word_next = win_d[PAT_W-1 -: WORD_W];
endmodule

// File: rtl/trs_word_divider.sv
// Resettable divide-by-word-width bit counter.
// The phase counts the bits of the current word already captured.
// A realign request forces phase 1, because the incoming bit is bit 0.
// Assumes realign is never asserted on two consecutive cycles.
module trs_word_divider #(
    parameter int WORD_W = 10,
    parameter int PH_W   = $clog2(WORD_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            realign,
    output logic            word_done,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

    // Word completes on this edge unless the phase is being realigned
    always_comb word_done = (phase == PH_LAST) && !realign;

    // Phase counter with forced restart
    always_ff @(posedge clk) begin
        if (!rst_n)                phase <= '0;
        else if (realign)          phase <= PH_ONE;
        else if (phase == PH_LAST) phase <= '0;
        else                       phase <= phase + PH_ONE;
    end
endmodule

// File: rtl/trs_frame_ctrl.sv
// Framing control.
// Registers completed words and their strobe, inverts the header level on
// each detection, and classifies the first word after a header by its H bit.
// Assumes hdr_hit and word_done come from the same clock domain.
module trs_frame_ctrl
    import trs_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int H_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_hit,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_next,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb,
    output logic              h_level,
    output logic              hdr_eav
);
    frame_state_e state;

    // Parallel word output and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= word_done;
            if (word_done) word_out <= word_next;
        end
    end

    // Level change per detected header
    always_ff @(posedge clk) begin
        if (!rst_n)       h_level <= 1'b0;
        else if (hdr_hit) h_level <= ~h_level;
    end

    // Marker classification state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_TRACK;
            hdr_eav <= 1'b0;
        end else if (hdr_hit) begin
            state <= ST_CLASSIFY;
        end else if (state == ST_CLASSIFY && word_done) begin
            state   <= ST_TRACK;
            hdr_eav <= word_next[H_BIT];
        end
    end
endmodule

// File: rtl/trs_framer.sv
// Top of the serial word framer.
// Header detection realigns the word divider and drives the framing control.
// Assumes the input is already descrambled and NRZ, one bit per clock.
module trs_framer #(
    parameter int WORD_W    = trs_pkg::WORD_W_DEF,
    parameter int HDR_WORDS = trs_pkg::HDR_WORDS_DEF,
    parameter int XYZ_H_BIT = trs_pkg::H_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    output logic [WORD_W-1:0] par_word,
    output logic              word_stb,
    output logic              h_level,
    output logic              hdr_eav
);
    localparam int PH_W = $clog2(WORD_W);

    logic              hdr_hit;
    logic              word_done;
    logic [PH_W-1:0]   phase;
    logic [WORD_W-1:0] word_next;

    trs_seq_detect #(.WORD_W(WORD_W), .HDR_WORDS(HDR_WORDS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (ser_bit),
        .word_next (word_next),
        .hdr_hit   (hdr_hit)
    );

    trs_word_divider #(.WORD_W(WORD_W), .PH_W(PH_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .realign   (hdr_hit),
        .word_done (word_done),
        .phase     (phase)
    );

    trs_frame_ctrl #(.WORD_W(WORD_W), .H_BIT(XYZ_H_BIT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_hit   (hdr_hit),
        .word_done (word_done),
        .word_next (word_next),
        .word_out  (par_word),
        .word_stb  (word_stb),
        .h_level   (h_level),
        .hdr_eav   (hdr_eav)
    );
endmodule

// File: rtl/trs_framer_chk.sv
// Property checker for the serial word framer, attached by bind.
// Relates header detection, divider phase and the framing outputs over time.
module trs_framer_chk #(
    parameter int WORD_W = 10,
    parameter int PH_W   = $clog2(WORD_W)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hdr_hit,
    input logic [PH_W-1:0] phase,
    input logic            word_stb,
    input logic            h_level
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb); // R2

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < WORD_W); // R2

    AST_H_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_hit |=> (h_level != $past(h_level))); // R5

    AST_H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_hit |=> $stable(h_level)); // R9

    AST_REALIGN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_hit |=> (int'(phase) == 1)); // R6

    AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_hit |=> !word_stb); // R7
endmodule

bind trs_framer trs_framer_chk #(.WORD_W(WORD_W), .PH_W(PH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_hit  (hdr_hit),
    .phase    (phase),
    .word_stb (word_stb),
    .h_level  (h_level)
);

// File: tb/trs_framer_tb.sv
// Directed bench for the serial word framer: one task per scenario.
module trs_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic [9:0] par_word;
    logic       word_stb;
    logic       h_level;
    logic       hdr_eav;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_stb_cyc = 0;
    int gap = 0;
    int stb_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trs_framer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_bit  (ser_bit),
        .par_word (par_word),
        .word_stb (word_stb),
        .h_level  (h_level),
        .hdr_eav  (hdr_eav)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Drive one bit, step past the edge, record strobes
    task automatic send_bit(input logic b);
        ser_bit = b;
        @(posedge clk);
        #1;
        cyc++;
        if (word_stb) begin
            stb_cnt++;
            gap = cyc - last_stb_cyc;
            last_stb_cyc = cyc;
        end
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    // Send a word that should be strobed at its last bit with a 10-cycle gap
    task automatic send_checked(input logic [9:0] w, input string req);
        int c0;
        c0 = stb_cnt;
        send_word(w);
        check(word_stb == 1'b1, req, word_stb, 1);
        check(par_word == w, req, par_word, w);
        check(stb_cnt - c0 == 1 && gap == 10, req, gap, 10);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        ser_bit = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(word_stb == 0 && h_level == 0 && hdr_eav == 0 && par_word == 0,
              "R1", {word_stb, h_level, hdr_eav, par_word}, 0);
        rst_n = 1'b1;
        ser_bit = 1'b0;
    endtask

    task automatic t_free_run();
        int c0;
        c0 = stb_cnt;
        // first strobe exactly on the 10th bit after reset
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        check(stb_cnt == c0, "R2", stb_cnt - c0, 0);
        send_bit(1'b0);
        check(word_stb == 1'b1 && par_word == 10'h1FF, "R2", par_word, 10'h1FF);
        send_checked(10'h155, "R3");
        send_checked(10'h0F3, "R3");
        send_checked(10'h2A5, "R2");
    endtask

    // Header at a pad offset, then a marker word; checks R4..R8
    task automatic t_header(input int pad, input logic [9:0] xyz, input logic exp_eav);
        logic h0;
        int c0;
        h0 = h_level;
        for (int i = 0; i < pad; i++) send_bit(1'b0);
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h000);
        check(h_level == h0, "R5", h_level, h0);
        c0 = stb_cnt;
        send_bit(xyz[0]);
        check(h_level == ~h0, "R4", h_level, ~h0);
        check(word_stb == 1'b0, "R7", word_stb, 0);
        for (int i = 1; i < 10; i++) send_bit(xyz[i]);
        check(stb_cnt - c0 == 1 && word_stb == 1'b1, "R6", stb_cnt - c0, 1);
        check(par_word == xyz, "R6", par_word, xyz);
        check(hdr_eav == exp_eav, "R8", hdr_eav, exp_eav);
        send_checked(10'h155, "R6");
        check(hdr_eav == exp_eav, "R8", hdr_eav, exp_eav);
    endtask

    // Header at the current phase: spacing unbroken
    task automatic t_aligned();
        send_checked(10'h3FF, "R10");
        send_checked(10'h000, "R10");
        send_checked(10'h000, "R10");
        send_checked(10'h200, "R10");
        check(hdr_eav == 1'b0, "R8", hdr_eav, 0);
        send_checked(10'h0AA, "R10");
    endtask

    // Windows one bit away from the header leave the level alone
    task automatic t_near_miss();
        logic h0;
        h0 = h_level;
        send_checked(10'h155, "R9");
        send_checked(10'h1FF, "R9");
        send_checked(10'h000, "R9");
        send_checked(10'h000, "R9");
        send_checked(10'h3FF, "R9");
        send_checked(10'h000, "R9");
        send_checked(10'h001, "R9");
        send_checked(10'h0CC, "R9");
        check(h_level == h0, "R9", h_level, h0);
    endtask

    initial begin
        t_reset();
        t_free_run();
        t_header(9, 10'h2D8, 1'b1);
        t_header(4, 10'h200, 1'b0);
        t_aligned();
        t_near_miss();
        t_header(7, 10'h3C4, 1'b1);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule